// File: doc/BRIEF.md
# Selectable Serial Line-Code Encoder

This block turns a stream of single data bits into a line waveform in one of five codes. A three-bit mode input selects the code: non-return-to-zero, invert-on-one, return-to-zero, bipolar return-to-zero or Manchester. The block runs from a clock at twice the bit rate, so every bit cell lasts two clock cycles, called the first and second half-cells. The two-bit output carries three line levels: zero, positive and negative.

Bits arrive through a valid/ready handshake. Ready is high in the second half of every cell, which is the cell boundary slot. A bit offered with valid in that cycle is taken at the clock edge that ends it. The mode is captured together with the bit. The next two cycles then drive that cell's two half-cell levels. If no bit is offered at a boundary, the following cell is idle and the line sits at zero. The invert-on-one level and the bipolar pulse polarity are kept across cells and are cleared by reset.

Top module: `lc_encoder`

## Requirements
- R1: While reset is active and in the first cycle after it, line_out is 2'b00 and in_ready is 1. Reset clears the invert-on-one level to low. It also clears the bipolar polarity so that the next bipolar 1 is a positive pulse.
- R2: in_ready is 1 in every second half-cell and 0 in every first half-cell, and the two alternate each cycle. A bit is accepted on the edge where in_valid and in_ready are both 1. Its cell drives line_out for the next two cycles: the first half-cell, then the second.
- R3: line_out encodes zero as 2'b00, positive as 2'b01 and negative as 2'b11. It never shows 2'b10.
- R4: In mode 3'd0 (NRZ), a 1 gives positive for both half-cells and a 0 gives zero for both.
- R5: In mode 3'd1 (invert-on-one), a 1 inverts the stored level at the start of the cell and a 0 keeps it. Both half-cells show positive when the level is high and zero when it is low.
- R6: In mode 3'd2 (RZ), a 1 gives positive in the first half-cell and zero in the second. A 0 gives zero in both.
- R7: In mode 3'd3 (bipolar RZ), each 1 gives a pulse in the first half-cell and zero in the second. Successive bipolar 1s alternate positive and negative. A 0 gives zero. Only bipolar 1s advance the polarity.
- R8: In mode 3'd4 (Manchester), a 1 gives zero then positive and a 0 gives positive then zero, so the level changes at mid-cell in every cell.
- R9: When in_valid is 0 at a boundary, both half-cells of the next cell are zero. The invert-on-one level and the bipolar polarity stay unchanged.
- R10: The mode is sampled only when a bit is accepted. A change of the mode input during a cell does not alter that cell's second half-cell.
- R11: Mode codes 3'd5 to 3'd7 give zero in both half-cells. They leave the invert-on-one level and the bipolar polarity unchanged.
- R12: The invert-on-one level changes only on accepted 1s in mode 3'd1. A 1 sent in any other mode leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Data bit value |
| in_ready | output | 1 | Cell boundary slot; a bit is taken at this edge if valid |
| mode | input | 3 | Line-code select, sampled with the bit |
| line_out | output | 2 | Line level: 00 zero, 01 positive, 11 negative |

## Verification
The bench follows the polarity state across bipolar runs that are broken by zeros, idle cells and 1s in other modes. An encoder that advanced the polarity on any 1 would put out the wrong sign after such a break. It also shows the stored invert-on-one level with a 0 cell after idle cells, unknown mode codes and 1s in foreign modes. A design that toggled on those would show a flipped level there. It changes the mode in the middle of cells, which catches a second half-cell taken from the live mode input. It also checks that both Manchester polarities move at mid-cell, which catches a swapped or missing transition.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int LVL_W  = 2;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LC_NRZ   = 3'd0,
    LC_NRZI  = 3'd1,
    LC_RZ    = 3'd2,
    LC_BPRZ  = 3'd3,
    LC_MANCH = 3'd4
  } lc_mode_e;

  localparam logic [LVL_W-1:0] LVL_ZERO = 2'b00;
  localparam logic [LVL_W-1:0] LVL_POS  = 2'b01;
  localparam logic [LVL_W-1:0] LVL_NEG  = 2'b11;

  typedef struct packed {
    logic              active;
    lc_mode_e          mode;
    logic [LVL_W-1:0]  first;
    logic [LVL_W-1:0]  second;
  } lc_cell_t;

  function automatic logic [LVL_W-1:0] lc_unipolar(input logic on);
    return on ? LVL_POS : LVL_ZERO;
  endfunction

  // next invert-on-one level after a cell
  function automatic logic lc_nrzi_step(input lc_mode_e m, input logic b, input logic lvl);
    return (m == LC_NRZI && b) ? ~lvl : lvl;
  endfunction

  // next bipolar polarity after a cell (1 = next pulse negative)
  function automatic logic lc_pol_step(input lc_mode_e m, input logic b, input logic neg);
    return (m == LC_BPRZ && b) ? ~neg : neg;
  endfunction

  // {first, second} half-cell levels for one accepted bit
  function automatic logic [2*LVL_W-1:0] lc_cell_levels(input lc_mode_e m, input logic b,
                                                        input logic nrzi_next, input logic neg);
    logic [LVL_W-1:0] f, s;
    f = LVL_ZERO;
    s = LVL_ZERO;
    case (m)
      LC_NRZ:   begin f = lc_unipolar(b);         s = f;        end
      LC_NRZI:  begin f = lc_unipolar(nrzi_next); s = f;        end
      LC_RZ:    begin f = lc_unipolar(b);         s = LVL_ZERO; end
      LC_BPRZ:  begin f = b ? (neg ? LVL_NEG : LVL_POS) : LVL_ZERO; s = LVL_ZERO; end
      LC_MANCH: begin f = lc_unipolar(~b);        s = lc_unipolar(b); end
      default:  begin f = LVL_ZERO;               s = LVL_ZERO; end
    endcase
    return {f, s};
  endfunction

endpackage

// File: rtl/lc_cell_timer.sv
module lc_cell_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic half_q,
  output logic in_ready,
  output logic accept
);

  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b1;
    else        half_q <= ~half_q;
  end

  assign in_ready = half_q;
  assign accept   = in_valid & half_q;

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

endmodule

// File: rtl/lc_line_state.sv
module lc_line_state
  import lc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  lc_mode_e mode,
  input  logic     in_bit,
  output logic     nrzi_next,
  output logic     neg_q
);

  logic nrzi_q;

  assign nrzi_next = lc_nrzi_step(mode, in_bit, nrzi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrzi_q <= 1'b0;
      neg_q  <= 1'b0;
    end else if (accept) begin
      nrzi_q <= nrzi_next;
      neg_q  <= lc_pol_step(mode, in_bit, neg_q);
    end
  end

  // R12
  nrzi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && mode == LC_NRZI && in_bit) |=> $stable(nrzi_q));
  // R7
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && mode == LC_BPRZ && in_bit) |=> $stable(neg_q));
  // R7
  pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == LC_BPRZ && in_bit) |=> (neg_q != $past(neg_q)));

endmodule

// File: rtl/lc_level_map.sv
module lc_level_map
  import lc_pkg::*;
(
  input  lc_mode_e          mode,
  input  logic              in_bit,
  input  logic              nrzi_next,
  input  logic              neg_q,
  output logic [LVL_W-1:0]  first_lvl,
  output logic [LVL_W-1:0]  second_lvl
);

  always_comb begin
    {first_lvl, second_lvl} = lc_cell_levels(mode, in_bit, nrzi_next, neg_q);
  end

  // R3
  always_comb begin
    lvl_legal_chk: assert (first_lvl != 2'b10 && second_lvl != 2'b10);
  end

endmodule

// File: rtl/lc_encoder.sv
module lc_encoder
  import lc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  input  logic [MODE_W-1:0] mode,
  output logic [LVL_W-1:0]  line_out
);

  lc_mode_e         mode_e;
  logic             half_q;
  logic             accept;
  logic             nrzi_next;
  logic             neg_q;
  logic [LVL_W-1:0] first_lvl, second_lvl;
  lc_cell_t         cell_q;

  assign mode_e = lc_mode_e'(mode);

  lc_cell_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .half_q   (half_q),
    .in_ready (in_ready),
    .accept   (accept)
  );

  lc_line_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .mode      (mode_e),
    .in_bit    (in_bit),
    .nrzi_next (nrzi_next),
    .neg_q     (neg_q)
  );

  lc_level_map u_map (
    .mode       (mode_e),
    .in_bit     (in_bit),
    .nrzi_next  (nrzi_next),
    .neg_q      (neg_q),
    .first_lvl  (first_lvl),
    .second_lvl (second_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_q <= '{active: 1'b0, mode: LC_NRZ, first: LVL_ZERO, second: LVL_ZERO};
    end else if (half_q) begin
      cell_q.active <= accept;
      if (accept) begin
        cell_q.mode   <= mode_e;
        cell_q.first  <= first_lvl;
        cell_q.second <= second_lvl;
      end else begin
        cell_q.first  <= LVL_ZERO;
        cell_q.second <= LVL_ZERO;
      end
    end
  end

  assign line_out = half_q ? cell_q.second : cell_q.first;

  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_out != 2'b10);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_q.active |-> line_out == LVL_ZERO);
  // R6
  rz_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_q.active && half_q && (cell_q.mode == LC_RZ || cell_q.mode == LC_BPRZ))
      |-> line_out == LVL_ZERO);
  // R8
  manch_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_q.active && cell_q.mode == LC_MANCH && !half_q) |=> line_out != $past(line_out));
  // R4
  nrz_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_q.active && cell_q.mode == LC_NRZ && !half_q) |=> line_out == $past(line_out));
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_q |=> $stable(cell_q));

endmodule

// File: tb/test_lc_encoder.sv
module test_lc_encoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       in_ready;
  logic [1:0] line_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side line state
  logic m_lvl = 1'b0;   // invert-on-one level
  logic m_neg = 1'b0;   // next bipolar pulse negative

  always #10 clk = ~clk;

  lc_encoder i_lc_encoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_ready (in_ready),
    .mode     (mode),
    .line_out (line_out)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic expect_cell(input logic v, input logic b, input logic [2:0] m,
                             output logic [1:0] e1, output logic [1:0] e2);
    e1 = 2'b00; e2 = 2'b00;
    if (v) begin
      if (m == 3'd0) begin e1 = b ? 2'b01 : 2'b00; e2 = e1; end
      else if (m == 3'd1) begin
        if (b) m_lvl = !m_lvl;
        e1 = m_lvl ? 2'b01 : 2'b00; e2 = e1;
      end
      else if (m == 3'd2) e1 = b ? 2'b01 : 2'b00;
      else if (m == 3'd3) begin
        if (b) begin e1 = m_neg ? 2'b11 : 2'b01; m_neg = !m_neg; end
      end
      else if (m == 3'd4) begin e1 = b ? 2'b00 : 2'b01; e2 = b ? 2'b01 : 2'b00; end
    end
  endtask

  // called at a negedge with in_ready high; returns at the next such negedge
  task automatic do_cell(input logic v, input logic b, input logic [2:0] m,
                         input logic [2:0] m_mid, input string tag);
    logic [1:0] e1, e2;
    in_valid = v; in_bit = b; mode = m;
    @(posedge clk); @(negedge clk);
    expect_cell(v, b, m, e1, e2);
    chk({tag, " first half"}, line_out, e1);
    chk("R2 ready low in first half", {1'b0, in_ready}, 2'b00);
    chk("R3 legal code", {1'b0, line_out == 2'b10}, 2'b00);
    in_valid = 1'b0; in_bit = ~b; mode = m_mid;
    @(posedge clk); @(negedge clk);
    chk({tag, " second half"}, line_out, e2);
    chk("R2 ready high in second half", {1'b0, in_ready}, 2'b01);
  endtask

  task automatic t_reset;
    chk("R1 line zero after reset", line_out, 2'b00);
    chk("R1 ready after reset", {1'b0, in_ready}, 2'b01);
  endtask

  task automatic t_nrz;
    do_cell(1, 1, 3'd0, 3'd0, "R4 nrz 1");
    do_cell(1, 0, 3'd0, 3'd0, "R4 nrz 0");
    do_cell(1, 1, 3'd0, 3'd0, "R4 nrz 1b");
    do_cell(1, 1, 3'd0, 3'd0, "R4 nrz 1c");
  endtask

  task automatic t_nrzi;
    do_cell(1, 1, 3'd1, 3'd1, "R5 nrzi first 1 (R1 level low)");
    do_cell(1, 1, 3'd1, 3'd1, "R5 nrzi 1");
    do_cell(1, 0, 3'd1, 3'd1, "R5 nrzi 0");
    do_cell(1, 1, 3'd1, 3'd1, "R5 nrzi 1b");
    do_cell(1, 0, 3'd1, 3'd1, "R5 nrzi hold");
  endtask

  task automatic t_rz;
    do_cell(1, 1, 3'd2, 3'd2, "R6 rz 1");
    do_cell(1, 0, 3'd2, 3'd2, "R6 rz 0");
    do_cell(1, 1, 3'd2, 3'd2, "R6 rz 1b");
  endtask

  task automatic t_bprz;
    do_cell(1, 1, 3'd3, 3'd3, "R7 bprz first 1 positive (R1)");
    do_cell(1, 0, 3'd3, 3'd3, "R7 bprz 0");
    do_cell(1, 1, 3'd3, 3'd3, "R7 bprz 1 negative");
    do_cell(1, 1, 3'd3, 3'd3, "R7 bprz 1 positive");
    do_cell(1, 1, 3'd0, 3'd0, "R7 nrz 1 between");
    do_cell(1, 1, 3'd2, 3'd2, "R7 rz 1 between");
    do_cell(1, 1, 3'd3, 3'd3, "R7 bprz 1 after other modes");
  endtask

  task automatic t_manch;
    do_cell(1, 1, 3'd4, 3'd4, "R8 manch 1");
    do_cell(1, 0, 3'd4, 3'd4, "R8 manch 0");
    do_cell(1, 0, 3'd4, 3'd4, "R8 manch 0b");
    do_cell(1, 1, 3'd4, 3'd4, "R8 manch 1b");
  endtask

  task automatic t_idle;
    do_cell(0, 1, 3'd1, 3'd1, "R9 idle nrzi 1");
    do_cell(0, 1, 3'd3, 3'd3, "R9 idle bprz 1");
    do_cell(0, 0, 3'd4, 3'd4, "R9 idle manch");
    do_cell(1, 0, 3'd1, 3'd1, "R9 nrzi level kept over idle");
    do_cell(1, 1, 3'd3, 3'd3, "R9 bprz polarity kept over idle");
  endtask

  task automatic t_mode_mid;
    do_cell(1, 1, 3'd0, 3'd2, "R10 nrz with mid change to rz");
    do_cell(1, 0, 3'd4, 3'd0, "R10 manch with mid change to nrz");
    do_cell(1, 1, 3'd2, 3'd0, "R10 rz with mid change to nrz");
  endtask

  task automatic t_bad_mode;
    do_cell(1, 1, 3'd5, 3'd5, "R11 mode 5");
    do_cell(1, 1, 3'd6, 3'd6, "R11 mode 6");
    do_cell(1, 0, 3'd7, 3'd7, "R11 mode 7");
    do_cell(1, 0, 3'd1, 3'd1, "R11 nrzi level untouched");
    do_cell(1, 1, 3'd3, 3'd3, "R11 bprz polarity untouched");
  endtask

  task automatic t_nrzi_isolation;
    do_cell(1, 1, 3'd1, 3'd1, "R12 nrzi set level");
    do_cell(1, 1, 3'd0, 3'd0, "R12 nrz 1");
    do_cell(1, 1, 3'd4, 3'd4, "R12 manch 1");
    do_cell(1, 1, 3'd3, 3'd3, "R12 bprz 1");
    do_cell(1, 0, 3'd1, 3'd1, "R12 nrzi level unchanged");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nrz();
    t_nrzi();
    t_rz();
    t_bprz();
    t_manch();
    t_idle();
    t_mode_mid();
    t_bad_mode();
    t_nrzi_isolation();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule